// File: doc/BRIEF.md
# Configurable-Format UART Transceiver

This block is a full-duplex asynchronous serial transmitter and receiver. Four control inputs choose the frame layout while the block is running: the number of data bits (seven or eight), the number of stop bits (one or two), and the parity (none, even or odd). Both directions are paced by an external sampling-tick enable. One bit period lasts sixteen ticks. The baud-rate divider that produces the tick is outside this block.

Bytes to send are accepted through a valid/ready handshake. Each received byte is returned with a one-cycle valid strobe, together with a parity-error flag and a framing-error flag. A single enable input starts and stops the unit. The four format inputs are captured only while the enable is low. A change made while the unit runs therefore has no effect until the next halt.

Top module: `fmt_uart`

## Requirements
- R1: While `en` is low, `txd` is held high, `tx_ready` is low, any frame in progress is abandoned, and no byte is delivered on `rx_valid`, whatever arrives on `rxd`.
- R2: The format inputs `fmt_8bit`, `fmt_2stop`, `fmt_par_en` and `fmt_par_odd` are captured only while `en` is low, and all four reset to 0. A change made while `en` is high affects neither direction until `en` has been low again.
- R3: The line idles high. A transmitted frame is sent in this order: one low start bit, the data bits starting with bit 0 (LSB first), the parity bit when `fmt_par_en`=1, then one high stop bit (`fmt_2stop`=0) or two high stop bits (`fmt_2stop`=1). Each bit lasts 16 `sample_tick` pulses, counted from the clock edge that accepts the byte.
- R4: With `fmt_8bit`=0 the frame carries seven data bits. The transmitter ignores `tx_data[7]`, and the receiver returns `rx_data[7]` as 0.
- R5: With parity enabled, the parity bit makes the number of ones among the data bits plus the parity bit even when `fmt_par_odd`=0, and odd when `fmt_par_odd`=1.
- R6: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until 16·N ticks later, where N is the total number of bits in the frame (9 to 12). It rises on the edge that consumes the last tick of the final stop bit.
- R7: The receiver decodes all eight frame layouts. For each frame it pulses `rx_valid` for exactly one cycle, with the data on `rx_data`.
- R8: When parity is enabled and the received parity bit does not match the configured sense, `rx_perr` is set, and the data byte is still delivered. With parity disabled, `rx_perr` is always 0.
- R9: `rx_ferr` is set when any expected stop bit, including the second of two, is sampled low. The byte is still delivered.
- R10: A falling edge on the line is taken as a start bit only if the line is still low on the 8th tick after the tick that detected it. A low pulse shorter than that produces no byte. Each later bit is sampled every 16 ticks after that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; format captured while low |
| sample_tick | input | 1 | Sampling enable, 16 per bit period |
| fmt_8bit | input | 1 | 1: eight data bits, 0: seven |
| fmt_2stop | input | 1 | 1: two stop bits, 0: one |
| fmt_par_en | input | 1 | 1: parity bit present and checked |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_perr | output | 1 | Parity mismatch on the delivered byte |
| rx_ferr | output | 1 | Stop bit sampled low on the delivered byte |

## Verification
The bench covers all eight layouts with random bytes in loopback. It checks every line bit at mid-period against its own frame model, so a design that emits the parity bit ahead of the data or drops the second stop bit shows a wrong bit at a known tick. It also measures the ready window to the exact tick: an off-by-one bit counter releases `tx_ready` 16 ticks early or late. Frames injected directly into the receiver carry flipped parity, a bad first stop bit or a bad second stop bit only, which exposes a design that checks just one stop bit or swaps the parity sense. A short glitch, format changes made while running, and traffic while halted exercise start qualification, the format capture and the enable gating.

// File: rtl/fmt_uart_pkg.sv
package fmt_uart_pkg;

    localparam int FRAME_MAX = 12;
    localparam int CAPT_MAX  = FRAME_MAX - 1;

    typedef struct packed {
        logic eight;
        logic two_stop;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_word_t;

    function automatic logic [3:0] frame_len(frame_cfg_t c);
        return 4'd1 + (c.eight ? 4'd8 : 4'd7) + {3'b000, c.par_en}
             + (c.two_stop ? 4'd2 : 4'd1);
    endfunction

    function automatic logic par_bit(frame_cfg_t c, logic [7:0] d);
        logic [7:0] m;
        m = c.eight ? d : {1'b0, d[6:0]};
        return (^m) ^ c.par_odd;
    endfunction

    function automatic logic [FRAME_MAX-1:0] build_frame(frame_cfg_t c, logic [7:0] d);
        logic [FRAME_MAX-1:0] f;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || c.eight) f[i+1] = d[i];
        end
        if (c.par_en) begin
            if (c.eight) f[9] = par_bit(c, d);
            else         f[8] = par_bit(c, d);
        end
        return f;
    endfunction

    function automatic rx_word_t decode(frame_cfg_t c, logic [CAPT_MAX-1:0] b);
        rx_word_t   r;
        logic [3:0] dl;
        logic [3:0] sp;
        dl     = c.eight ? 4'd8 : 4'd7;
        r.data = c.eight ? b[7:0] : {1'b0, b[6:0]};
        r.perr = c.par_en && (b[dl] != par_bit(c, r.data));
        sp     = c.par_en ? dl + 4'd1 : dl;
        r.ferr = !b[sp] || (c.two_stop && !b[sp+4'd1]);
        return r;
    endfunction

endpackage

// File: rtl/fmt_uart_cfg.sv
module fmt_uart_cfg
    import fmt_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  frame_cfg_t cfg_in,
    output frame_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)      cfg_q <= '0;
        else if (!en) cfg_q <= cfg_in;
    end

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg_q));

endmodule

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx
    import fmt_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd
);

    localparam int CW = $clog2(OSR);

    logic                 busy;
    logic [FRAME_MAX-1:0] sh;
    logic [3:0]           left;
    logic [CW-1:0]        tcnt;

    assign tx_ready = en && !busy;
    assign txd      = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            tcnt <= '0;
        end else if (!busy) begin
            if (tx_valid) begin
                busy <= 1'b1;
                sh   <= build_frame(cfg, tx_data);
                left <= frame_len(cfg);
                tcnt <= '0;
            end
        end else if (tick) begin
            if (tcnt == CW'(OSR - 1)) begin
                tcnt <= '0;
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assert_ready_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

endmodule

// File: rtl/fmt_uart_rx.sv
module fmt_uart_rx
    import fmt_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr
);

    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [1:0]          sync;
    logic                rx_s;
    rx_state_t           st;
    logic [CW-1:0]       cnt;
    logic [3:0]          idx;
    logic [CAPT_MAX-1:0] bits;
    logic [CAPT_MAX-1:0] bits_nx;
    logic [3:0]          last_idx;
    rx_word_t            word;

    assign rx_s     = sync[1];
    assign last_idx = frame_len(cfg) - 4'd2;

    always_comb begin
        bits_nx      = bits;
        bits_nx[idx] = rx_s;
        word         = decode(cfg, bits_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            bits     <= '1;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!en) begin
                st <= RX_IDLE;
            end else if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rx_s ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CW'(OSR - 1)) begin
                            cnt  <= '0;
                            bits <= bits_nx;
                            idx  <= idx + 4'd1;
                            if (idx == last_idx) begin
                                st       <= RX_IDLE;
                                rx_valid <= 1'b1;
                                rx_data  <= word.data;
                                rx_perr  <= word.perr;
                                rx_ferr  <= word.ferr;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_seven_bit_msb_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg.eight) |-> !rx_data[7]);

    assert_no_perr_unchecked_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg.par_en) |-> !rx_perr);

endmodule

// File: rtl/fmt_uart.sv
module fmt_uart
    import fmt_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       sample_tick,
    input  logic       fmt_8bit,
    input  logic       fmt_2stop,
    input  logic       fmt_par_en,
    input  logic       fmt_par_odd,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr
);

    frame_cfg_t cfg_in;
    frame_cfg_t cfg_q;

    assign cfg_in = '{eight: fmt_8bit, two_stop: fmt_2stop,
                      par_en: fmt_par_en, par_odd: fmt_par_odd};

    fmt_uart_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    fmt_uart_tx #(.OSR(OSR)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (sample_tick),
        .cfg      (cfg_q),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    fmt_uart_rx #(.OSR(OSR)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (sample_tick),
        .cfg      (cfg_q),
        .rxd      (rxd),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr)
    );

    assert_halt_line_high_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> txd);

    assert_halt_no_rx_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !rx_valid);

endmodule

// File: tb/fmt_uart_test.sv
module fmt_uart_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       sample_tick = 1'b0;
    logic       fmt_8bit = 1'b0, fmt_2stop = 1'b0, fmt_par_en = 1'b0, fmt_par_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr;
    logic       loop = 1'b1;
    logic       line_drv = 1'b1;

    int vectors = 0;
    int errors  = 0;
    int cap_n   = 0;
    logic [7:0] cap_data;
    logic       cap_perr, cap_ferr;

    int bdl = 7, bpe = 0, bodd = 0, btwo = 0;

    assign rxd = loop ? txd : line_drv;

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_n    = cap_n + 1;
            cap_data = rx_data;
            cap_perr = rx_perr;
            cap_ferr = rx_ferr;
        end
    end

    fmt_uart uut (
        .clk (clk), .rst (rst), .en (en), .sample_tick (sample_tick),
        .fmt_8bit (fmt_8bit), .fmt_2stop (fmt_2stop),
        .fmt_par_en (fmt_par_en), .fmt_par_odd (fmt_par_odd),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready), .txd (txd),
        .rxd (rxd), .rx_data (rx_data), .rx_valid (rx_valid),
        .rx_perr (rx_perr), .rx_ferr (rx_ferr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected line bits from the bench's own format variables
    task automatic model(input logic [7:0] d, output logic [15:0] fb, output int fl);
        int n = 0;
        int ones = 0;
        fb = '1;
        fb[n] = 1'b0; n++;
        for (int i = 0; i < bdl; i++) begin
            fb[n] = d[i]; n++;
            if (d[i]) ones++;
        end
        if (bpe != 0) begin
            fb[n] = (bodd != 0) ? ~ones[0] : ones[0];
            n++;
        end
        n = n + ((btwo != 0) ? 2 : 1);
        fl = n;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!sample_tick) @(posedge clk);
        end
    endtask

    task automatic set_fmt(input int dl, input int two, input int pe, input int odd);
        @(negedge clk);
        en = 1'b0;
        fmt_8bit = (dl == 8); fmt_2stop = (two != 0);
        fmt_par_en = (pe != 0); fmt_par_odd = (odd != 0);
        bdl = dl; btwo = two; bpe = pe; bodd = odd;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic send_chk(input logic [7:0] d);
        logic [15:0] fb;
        int fl, n0, k;
        logic [7:0] expd;
        model(d, fb, fl);
        n0 = cap_n;
        loop = 1'b1;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0; tx_data = 8'($urandom);
        chk("R6 ready low after accept", {31'b0, tx_ready}, 0);
        k = 0;
        while (k < 16 * fl) begin
            @(posedge clk);
            if (sample_tick) begin
                k++;
                @(negedge clk);
                if (k % 16 == 8) begin
                    if (bpe != 0 && k / 16 == 1 + bdl)
                        chk("R5 parity bit", {31'b0, txd}, {31'b0, fb[k/16]});
                    else
                        chk("R3 frame bit", {31'b0, txd}, {31'b0, fb[k/16]});
                end
                if (k == 16 * fl - 1)
                    chk("R6 ready still low", {31'b0, tx_ready}, 0);
            end
        end
        chk("R6 ready back after frame", {31'b0, tx_ready}, 1);
        expd = (bdl == 8) ? d : {1'b0, d[6:0]};
        chk("R7 one byte received", cap_n, n0 + 1);
        chk("R7 loopback data", {24'b0, cap_data}, {24'b0, expd});
        chk("R8 no parity error", {31'b0, cap_perr}, 0);
        chk("R9 no framing error", {31'b0, cap_ferr}, 0);
        if (bdl == 7) chk("R4 msb zero", {31'b0, cap_data[7]}, 0);
    endtask

    task automatic rx_inject(input logic [7:0] d, input int flip_par, input int bad_stop);
        logic [15:0] fb;
        int fl, n0;
        logic [7:0] expd;
        model(d, fb, fl);
        if (flip_par != 0) fb[1+bdl] = ~fb[1+bdl];
        if (bad_stop >= 0) fb[1+bdl+bpe+bad_stop] = 1'b0;
        n0 = cap_n;
        loop = 1'b0;
        for (int i = 0; i < fl; i++) begin
            @(negedge clk);
            line_drv = fb[i];
            wait_ticks(16);
        end
        @(negedge clk);
        line_drv = 1'b1;
        wait_ticks(4);
        @(negedge clk);
        expd = (bdl == 8) ? d : {1'b0, d[6:0]};
        chk("R7 injected frame delivered", cap_n, n0 + 1);
        chk("R7 injected data", {24'b0, cap_data}, {24'b0, expd});
        chk("R8 parity flag", {31'b0, cap_perr}, {31'b0, flip_par != 0});
        chk("R9 framing flag", {31'b0, cap_ferr}, {31'b0, bad_stop >= 0});
        wait_ticks(24);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset line high", {31'b0, txd}, 1);
        chk("R1 reset not ready", {31'b0, tx_ready}, 0);
        chk("R1 reset no strobe", {31'b0, rx_valid}, 0);

        // R1: halted unit ignores traffic in both directions
        begin
            logic [15:0] fb;
            int fl, n0;
            model(8'h35, fb, fl);
            n0 = cap_n;
            loop = 1'b0;
            tx_valid = 1'b1; tx_data = 8'h00;
            for (int i = 0; i < fl; i++) begin
                @(negedge clk);
                line_drv = fb[i];
                wait_ticks(16);
                @(negedge clk);
                chk("R1 halted line high", {31'b0, txd}, 1);
                chk("R1 halted not ready", {31'b0, tx_ready}, 0);
            end
            @(negedge clk);
            line_drv = 1'b1; tx_valid = 1'b0;
            wait_ticks(8);
            chk("R1 halted receiver silent", cap_n, n0);
        end

        // Directed frames in the reset format (7 data, no parity, 1 stop)
        en = 1'b1;
        send_chk(8'hFF);
        send_chk(8'h80);

        // R2: pins changed while running are not taken
        @(negedge clk);
        fmt_8bit = 1'b1; fmt_2stop = 1'b1; fmt_par_en = 1'b1; fmt_par_odd = 1'b1;
        send_chk(8'hA5);
        send_chk(8'h7E);
        // R2: a halt takes them
        set_fmt(8, 1, 1, 1);
        send_chk(8'hA5);

        // Constrained random over all layouts
        for (int r = 0; r < 8; r++) begin
            set_fmt((r[0] ? 8 : 7), r[1], r[2], int'($urandom_range(0, 1)));
            for (int j = 0; j < 5; j++) send_chk(8'($urandom));
        end

        // Receiver error injection
        set_fmt(8, 0, 1, 0);
        rx_inject(8'h3C, 1, -1);
        rx_inject(8'h3C, 0, 0);
        set_fmt(7, 0, 1, 1);
        rx_inject(8'hD1, 1, -1);
        set_fmt(8, 1, 0, 0);
        rx_inject(8'h96, 0, 1);
        rx_inject(8'h96, 0, 0);
        rx_inject(8'h69, 0, -1);

        // R10: short low glitch is rejected
        begin
            int n0;
            n0 = cap_n;
            loop = 1'b0;
            @(negedge clk);
            line_drv = 1'b0;
            wait_ticks(4);
            @(negedge clk);
            line_drv = 1'b1;
            wait_ticks(200);
            @(negedge clk);
            chk("R10 glitch produces no byte", cap_n, n0);
        end
        rx_inject(8'h5A, 0, -1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule